// File: doc/BRIEF.md
# Packed Decimal Truncation Unit

This unit shortens a signed packed-decimal value to a smaller number of significant digits. The value operand is 128 bits wide and holds 32 nibbles. Nibble 0 is the sign code and nibbles 1 to 31 are decimal digits, with nibble 31 the most significant. The low five bits of a second 128-bit operand give how many of the top digits to clear. The unit forces those digits to zero. It rewrites the sign in its preferred code and returns the value together with a four-bit condition code.

The condition code reports whether the shortened value is below, above or equal to zero. It also reports whether any nonzero digit was thrown away. If an operand contains a malformed digit or sign, the unit leaves the value alone and raises only the overflow flag. One result appears per accepted request, one clock after the request strobe.

Top module: `bcd_trunc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `out_valid`, `result` and `cond` are all zero.
- R2: `out_valid` is high exactly on the cycle after a cycle with `in_valid` high. On a cycle with `in_valid` low, `result` and `cond` keep their previous values.
- R3: Let k be `src_ctl[4:0]`. Every digit nibble i (1 to 31) with i >= 32 - k reads zero in `result`. Every lower digit nibble is copied unchanged. Bits `src_ctl[127:5]` have no effect.
- R4: When the input is well formed, `cond[0]` (overflow) is 1 exactly when at least one cleared digit was nonzero. This is judged afresh for each request.
- R5: A digit nibble above 9, or a sign nibble below 0xA, makes the input malformed. In that case `cond` is 4'b0001 and `result` equals `src_val` unchanged.
- R6: For a well-formed input, sign codes 0xB and 0xD are negative and 0xA, 0xC, 0xE and 0xF are positive. The result sign is 0xD for negative. For positive it is 0xC when `pref_sel` is 0 and 0xF when `pref_sel` is 1.
- R7: For a well-formed input, `cond[3]` is LT, `cond[2]` is GT and `cond[1]` is EQ, comparing the result with zero. If all result digits are zero, the code is EQ whatever the sign. Otherwise it is LT for a negative sign and GT for a positive one, and exactly one of the three bits is set.
- R8: With k = 0 no digit is cleared and overflow stays 0. Only the sign code may change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; the operands are taken on this cycle |
| src_val | input | 128 | Signed packed-decimal operand, sign in bits [3:0] |
| src_ctl | input | 128 | Control operand; bits [4:0] give the count of top digits to clear |
| pref_sel | input | 1 | Positive sign code choice: 0 gives 0xC, 1 gives 0xF |
| out_valid | output | 1 | High one cycle after each request |
| result | output | 128 | Truncated value with the rewritten sign |
| cond | output | 4 | Condition code {LT, GT, EQ, overflow} |

## Verification
On every clock, the bound checker confirms several properties. These are the one-cycle strobe latency and the holding of idle outputs. They also cover the clearing of the selected digits, the copying of the digits below them, and the malformed-input code with its passthrough. Finally they check the legal sign codes and the mutual exclusion of LT, GT and EQ. Some behaviours need chosen operands to show. These are whether overflow fires only on a nonzero lost digit, which sign code follows from each input sign and `pref_sel`, and the EQ verdict on an all-zero negative value. The bench's directed and mixed scenarios cover these, and a behavioural model is compared on every cycle.

// File: rtl/bcdt_pkg.sv
package bcdt_pkg;

    localparam int NIB_W = 4;

    // condition code bit positions
    localparam int CC_LT = 3;
    localparam int CC_GT = 2;
    localparam int CC_EQ = 1;
    localparam int CC_SO = 0;

    localparam logic [NIB_W-1:0] SGN_NEG_PREF  = 4'hD;
    localparam logic [NIB_W-1:0] SGN_POS_PREF  = 4'hC;
    localparam logic [NIB_W-1:0] SGN_POS_ALT   = 4'hF;

    function automatic logic sign_is_neg(input logic [NIB_W-1:0] s);
        return (s == 4'hB) || (s == 4'hD);
    endfunction

    function automatic logic sign_is_bad(input logic [NIB_W-1:0] s);
        return s < 4'hA;
    endfunction

    function automatic logic [NIB_W-1:0] pref_sign(input logic neg, input logic alt);
        if (neg)
            return SGN_NEG_PREF;
        return alt ? SGN_POS_ALT : SGN_POS_PREF;
    endfunction

endpackage

// File: rtl/bcdt_digit_check.sv
module bcdt_digit_check
    import bcdt_pkg::*;
#(
    parameter int NIBBLES = 32,
    localparam int DW = NIBBLES * NIB_W
) (
    input  logic [DW-1:0] value,
    output logic          digit_bad,
    output logic          sign_bad
);

    logic [NIBBLES-1:1] bad_vec;

    for (genvar i = 1; i < NIBBLES; i++) begin : g_dig
        assign bad_vec[i] = value[i*NIB_W +: NIB_W] > 4'd9;
    end

    assign digit_bad = |bad_vec;
    assign sign_bad  = sign_is_bad(value[NIB_W-1:0]);

endmodule

// File: rtl/bcdt_trunc_mask.sv
module bcdt_trunc_mask
    import bcdt_pkg::*;
#(
    parameter int NIBBLES = 32,
    localparam int DW    = NIBBLES * NIB_W,
    localparam int CNT_W = $clog2(NIBBLES)
) (
    input  logic [DW-1:0]    value,
    input  logic [CNT_W-1:0] count,
    output logic [DW-1:0]    kept,
    output logic             lost,
    output logic             kept_zero
);

    logic [CNT_W:0]     thresh;
    logic [NIBBLES-1:1] clr_vec;
    logic [NIBBLES-1:1] lost_vec;
    logic [NIBBLES-1:1] live_vec;

    assign thresh = (CNT_W+1)'(NIBBLES) - {1'b0, count};

    for (genvar i = 1; i < NIBBLES; i++) begin : g_dig
        logic nz;
        assign nz          = value[i*NIB_W +: NIB_W] != '0;
        assign clr_vec[i]  = (CNT_W+1)'(i) >= thresh;
        assign lost_vec[i] = clr_vec[i] & nz;
        assign live_vec[i] = ~clr_vec[i] & nz;
        assign kept[i*NIB_W +: NIB_W] = clr_vec[i] ? '0 : value[i*NIB_W +: NIB_W];
    end

    assign kept[NIB_W-1:0] = value[NIB_W-1:0];
    assign lost      = |lost_vec;
    assign kept_zero = ~|live_vec;

endmodule

// File: rtl/bcd_trunc_unit.sv
module bcd_trunc_unit
    import bcdt_pkg::*;
#(
    parameter int NIBBLES = 32,
    localparam int DW    = NIBBLES * NIB_W,
    localparam int CNT_W = $clog2(NIBBLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] src_val,
    input  logic [DW-1:0] src_ctl,
    input  logic          pref_sel,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [3:0]    cond
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
        logic [3:0]    cc;
    } state_t;

    state_t st_d, st_q;

    logic          digit_bad, sign_bad;
    logic [DW-1:0] kept;
    logic          lost, kept_zero;
    logic          ctl_hi_unused;

    assign ctl_hi_unused = ^src_ctl[DW-1:CNT_W];

    bcdt_digit_check #(.NIBBLES(NIBBLES)) u_check (
        .value     (src_val),
        .digit_bad (digit_bad),
        .sign_bad  (sign_bad)
    );

    bcdt_trunc_mask #(.NIBBLES(NIBBLES)) u_mask (
        .value     (src_val),
        .count     (src_ctl[CNT_W-1:0]),
        .kept      (kept),
        .lost      (lost),
        .kept_zero (kept_zero)
    );

    always_comb begin
        logic neg;
        st_d     = st_q;
        st_d.vld = in_valid;
        neg      = sign_is_neg(src_val[NIB_W-1:0]);
        if (in_valid) begin
            if (digit_bad || sign_bad) begin
                st_d.res        = src_val;
                st_d.cc         = '0;
                st_d.cc[CC_SO]  = 1'b1;
            end else begin
                st_d.res = {kept[DW-1:NIB_W], pref_sign(neg, pref_sel)};
                st_d.cc[CC_LT] = ~kept_zero & neg;
                st_d.cc[CC_GT] = ~kept_zero & ~neg;
                st_d.cc[CC_EQ] = kept_zero;
                st_d.cc[CC_SO] = lost;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cond      = st_q.cc;

endmodule

// File: rtl/bcd_trunc_unit_checker.sv
module bcd_trunc_unit_checker #(
    parameter int NIBBLES = 32,
    localparam int DW = NIBBLES * 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] src_val,
    input logic [DW-1:0] src_ctl,
    input logic          pref_sel,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic [3:0]    cond
);

    logic [DW-1:0] kill_mask;
    logic          in_bad;
    logic          sel_unused;

    assign sel_unused = pref_sel ^ (^src_ctl[DW-1:5]);

    always_comb begin
        kill_mask = '0;
        in_bad    = src_val[3:0] < 4'hA;
        for (int i = 1; i < NIBBLES; i++) begin
            if (i >= NIBBLES - int'(src_ctl[4:0]))
                kill_mask[i*4 +: 4] = 4'hF;
            if (src_val[i*4 +: 4] > 4'd9)
                in_bad = 1'b1;
        end
    end

    // R1
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && cond == '0));

    assert_strobe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_strobe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(cond)));

    assert_top_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_bad) |=> ((result & $past(kill_mask)) == '0));

    assert_low_copied_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((result[DW-1:4] & ~$past(kill_mask[DW-1:4]))
                      == ($past(src_val[DW-1:4]) & ~$past(kill_mask[DW-1:4]))));

    assert_bad_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bad) |=> (cond == 4'b0001 && result == $past(src_val)));

    assert_sign_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond[3:1] != 3'b000) |->
            (result[3:0] == 4'hC || result[3:0] == 4'hD || result[3:0] == 4'hF));

    assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($onehot0(cond[3:1]) && (cond[3:1] != 3'b000 || cond == 4'b0001)));

    assert_eq_means_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond[1]) |-> (result[DW-1:4] == '0));

endmodule

bind bcd_trunc_unit bcd_trunc_unit_checker #(.NIBBLES(NIBBLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_val   (src_val),
    .src_ctl   (src_ctl),
    .pref_sel  (pref_sel),
    .out_valid (out_valid),
    .result    (result),
    .cond      (cond)
);

// File: tb/test_bcd_trunc_unit.sv
module test_bcd_trunc_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_val = '0;
    logic [127:0] src_ctl = '0;
    logic         pref_sel = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic [3:0]   cond;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [132:0] exp_q[$];
    logic [127:0] last_res = '0;
    logic [3:0]   last_cc  = '0;

    always #5 clk = ~clk;

    bcd_trunc_unit i_bcd_trunc_unit (
        .clk, .rst_n, .in_valid, .src_val, .src_ctl, .pref_sel,
        .out_valid, .result, .cond
    );

    function automatic void ref_model(input logic [127:0] val, input logic [127:0] ctl,
                                      input logic ps, output logic [127:0] res,
                                      output logic [3:0] cc);
        int  thr = 32 - int'(ctl[4:0]);
        bit  bad = 0, loss = 0, nz = 0, neg;
        res = val;
        for (int i = 1; i < 32; i++) begin
            int d = int'(val[i*4 +: 4]);
            if (d > 9) bad = 1;
            if (i >= thr) begin
                if (d != 0) loss = 1;
                res[i*4 +: 4] = 4'h0;
            end else if (d != 0) nz = 1;
        end
        if (val[3:0] < 4'hA) bad = 1;
        neg = (val[3:0] == 4'hB) || (val[3:0] == 4'hD);
        if (bad) begin
            res = val;
            cc  = 4'b0001;
        end else begin
            res[3:0] = neg ? 4'hD : (ps ? 4'hF : 4'hC);
            cc = {nz && neg, nz && !neg, !nz, loss};
        end
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [127:0] val, input logic [127:0] ctl,
                         input logic ps, input string req);
        logic [127:0] r;
        logic [3:0]   c;
        logic [132:0] e;
        @(negedge clk);
        in_valid = v; src_val = val; src_ctl = ctl; pref_sel = ps;
        if (v) begin
            ref_model(val, ctl, ps, r, c);
            last_res = r;
            last_cc  = c;
        end
        exp_q.push_back({v, last_res, last_cc});
        @(posedge clk);
        #1;
        e = exp_q.pop_front();
        check(req, "out_valid", 128'(out_valid), 128'(e[132]));
        check(req, "result", result, e[131:4]);
        check(req, "cond", 128'(cond), 128'(e[3:0]));
    endtask

    function automatic logic [127:0] mixed_val();
        logic [127:0] v;
        logic [3:0] signs[6] = '{4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
        for (int i = 1; i < 32; i++)
            v[i*4 +: 4] = 4'($urandom_range(0, 9));
        v[3:0] = signs[$urandom_range(0, 5)];
        if ($urandom_range(0, 15) == 0)
            v[$urandom_range(1, 31)*4 +: 4] = 4'hE;
        if ($urandom_range(0, 7) == 0)
            v[127:4] = (v[127:4] >> ($urandom_range(0, 30) * 4));
        return v;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "out_valid", 128'(out_valid), 128'd0);
        check("R1", "result", result, 128'd0);
        check("R1", "cond", 128'(cond), 128'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: count zero keeps all digits
        apply(1, 128'h1234_5678_9012_3456_7890_1234_5678_901C, 128'd0, 0, "R8");
        // R4: top digit lost
        apply(1, 128'h1234_5678_9012_3456_7890_1234_5678_901C, 128'd1, 0, "R4");
        // R7: all digits cleared on a negative value gives EQ plus overflow
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_007D, 128'd31, 0, "R7");
        // R4: cleared digits already zero, no overflow, negative LT
        apply(1, 128'h0000_0000_0000_0000_1234_5678_9012_345B, 128'd16, 0, "R4");
        // R3: high control bits ignored, count 3
        apply(1, 128'h0005_0000_0000_0000_0000_0000_0000_042A,
              128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFE3, 1, "R3");
        apply(1, 128'h0005_0000_0000_0000_0000_0000_0000_042A, 128'd3, 1, "R3");
        // R5: malformed digit and malformed sign
        apply(1, 128'h9000_0000_0000_0000_0000_0000_00A0_000C, 128'd4, 0, "R5");
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_0123, 128'd2, 1, "R5");
        // R2: idle cycles hold outputs
        apply(0, 128'h1111_1111_1111_1111_1111_1111_1111_111C, 128'd5, 1, "R2");
        apply(0, 128'h0, 128'd0, 0, "R2");
        // R6: sign rewrite choices
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_456E, 128'd0, 0, "R6");
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_456E, 128'd0, 1, "R6");
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_456B, 128'd7, 1, "R6");
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_456F, 128'd7, 0, "R6");
        // R7: negative zero input reports EQ
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_000B, 128'd0, 0, "R7");
        // R4: overflow cleared again on next request
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_099C, 128'd30, 0, "R4");
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_099C, 128'd29, 0, "R4");
        // R2: back-to-back then gap
        apply(1, 128'h0000_0000_0000_0000_0000_0000_0000_001D, 128'd0, 0, "R2");
        apply(0, 128'h0000_0000_0000_0000_0000_0000_0000_005C, 128'd0, 0, "R2");

        // mixed operands across all counts (R3, R4, R5, R6, R7)
        for (int n = 0; n < 200; n++) begin
            logic [127:0] ctl;
            ctl = {$urandom, $urandom, $urandom, $urandom};
            apply($urandom_range(0, 4) != 0, mixed_val(), ctl, 1'($urandom_range(0, 1)), "R3");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule